// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block sits beside one hardware thread and decides whether an incoming notification is addressed to a context running on that thread. If it is, the block also reports which privilege ring holds that context. The thread holds four ring context registers: physical, pool, OS and user. Software or a neighbouring controller loads them through a simple write port. Each lookup presents a notification format bit, a target block and index, an ignore flag and a logical server number. One cycle later the block returns a registered hit flag and a ring code.

The physical ring never stores a CAM value. It is compared against a hardware CAM value built on the fly from the chip block number and the thread number. A configuration bit selects whether the thread number is 7 or 8 bits wide. In format 0 the rings are tried in a fixed order. Format 1 is a user-level mode that matches only the user ring.

Top module: `tctx_cam_match`

## Requirements
- R1: While reset is asserted and in the first cycle after it, res_valid and res_hit are 0 and res_ring is 3'd7. All four rings come out of reset invalid, so a lookup misses until a ring is loaded.
- R2: res_valid equals q_valid of the previous cycle. A result uses the lookup inputs of that cycle and the ring contents held before any write made in the same cycle.
- R3: The hardware CAM is 32 bits. Bits 31:24 hold chip_blk. When cfg_tid8 is 0, bit 7 is 1, bits 6:0 hold thread_id[6:0] and all other bits are 0. When cfg_tid8 is 1, bit 8 is 1, bits 7:0 hold thread_id and all other bits are 0.
- R4: The physical ring (wr_ring 3) hits when it is valid and the target {q_blk, q_idx} equals the hardware CAM. Any word written to the physical ring is ignored.
- R5: In format 0 with q_ignore low, the rings are tried in the order physical, pool, OS. The first ring that hits is reported.
- R6: The pool ring (wr_ring 2) and the OS ring (wr_ring 1) each hit when the ring is valid and its stored 32-bit CAM equals {q_blk, q_idx}.
- R7: Format 0 with q_ignore high always misses.
- R8: Format 1 reports only the user ring (wr_ring 0). It hits when all of these hold: the OS ring is valid, the OS CAM equals the target, the user ring is valid, and the low 16 bits of the user word equal q_lserv.
- R9: wr_word is in big-endian byte order. wr_word[7:0] is the most significant byte of the stored word and wr_word[31:24] is the least significant byte.
- R10: On a miss, res_hit is 0 and res_ring is 7. On a hit, res_hit is 1 and res_ring is 3 for physical, 2 for pool, 1 for OS or 0 for user.
- R11: A write with wr_valid low invalidates the addressed ring, and later lookups skip it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tid8 | input | 1 | 1: 8-bit thread number, 0: 7-bit |
| chip_blk | input | 8 | Chip block number for the hardware CAM |
| thread_id | input | 8 | Hardware thread number |
| wr_en | input | 1 | Ring register write strobe |
| wr_ring | input | 2 | Ring written: 0 user, 1 OS, 2 pool, 3 physical |
| wr_valid | input | 1 | Valid flag written with the word |
| wr_word | input | 32 | Ring word, big-endian byte order |
| q_valid | input | 1 | Lookup strobe |
| q_fmt | input | 1 | Notification format bit |
| q_blk | input | 8 | Target block |
| q_idx | input | 24 | Target index |
| q_ignore | input | 1 | Ignore flag for low target bits |
| q_lserv | input | 16 | Logical server number (format 1) |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A ring matched |
| res_ring | output | 3 | Matched ring code, 7 when none |

## Verification
The hardest situation to reach from the ports is the priority fall-through. It needs several rings valid at once and all holding the same CAM, and that CAM must also equal the hardware CAM under the current thread-number width. Random targets almost never land on it. The stimulus therefore draws ring CAMs and targets from a small pool that always includes the current hardware CAM. A directed sequence then loads the physical, pool and OS rings with one value and invalidates them one at a time. Further directed cases cover a thread number with bit 7 set under both widths, and a write and a lookup issued in the same cycle.

// File: rtl/tctx_cam_pkg.sv
package tctx_cam_pkg;

    typedef enum logic [2:0] {
        RING_USER = 3'd0,
        RING_OS   = 3'd1,
        RING_POOL = 3'd2,
        RING_PHYS = 3'd3,
        RING_NONE = 3'd7
    } ring_id_e;

    localparam int NUM_RINGS = 4;
    localparam int SEL_USER  = 0;
    localparam int SEL_OS    = 1;
    localparam int SEL_POOL  = 2;
    localparam int SEL_PHYS  = 3;

endpackage

// File: rtl/tctx_ring_bank.sv
module tctx_ring_bank
    import tctx_cam_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LS_W   = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_ring,
    input  logic                  wr_valid,
    input  logic [WORD_W-1:0]     wr_word,
    output logic [NUM_RINGS-1:0]  ring_vld,
    output logic [WORD_W-1:0]     pool_cam,
    output logic [WORD_W-1:0]     os_cam,
    output logic [LS_W-1:0]       user_ls
);
    localparam int NBYTES = WORD_W / 8;

    logic [WORD_W-1:0] host_word;

    // Incoming word arrives most significant byte first in the low lane.
    for (genvar b = 0; b < NBYTES; b++) begin : g_swap
        assign host_word[8*b +: 8] = wr_word[8*(NBYTES-1-b) +: 8];
    end

    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_vld
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ring_vld[r] <= 1'b0;
            end else if (wr_en && (wr_ring == 2'(r))) begin
                ring_vld[r] <= wr_valid;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_cam <= '0;
            os_cam   <= '0;
            user_ls  <= '0;
        end else if (wr_en) begin
            unique case (wr_ring)
                2'(SEL_POOL): pool_cam <= host_word;
                2'(SEL_OS):   os_cam   <= host_word;
                2'(SEL_USER): user_ls  <= host_word[LS_W-1:0];
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/tctx_hw_cam.sv
module tctx_hw_cam #(
    parameter int BLK_W = 8,
    parameter int CAM_W = 32,
    parameter int TID_W = 8
) (
    input  logic              cfg_tid8,
    input  logic [BLK_W-1:0]  chip_blk,
    input  logic [TID_W-1:0]  thread_id,
    output logic [CAM_W-1:0]  hw_cam
);
    always_comb begin
        hw_cam = '0;
        hw_cam[CAM_W-1 -: BLK_W] = chip_blk;
        if (cfg_tid8) begin
            hw_cam[TID_W]       = 1'b1;
            hw_cam[TID_W-1:0]   = thread_id;
        end else begin
            hw_cam[TID_W-1]     = 1'b1;
            hw_cam[TID_W-2:0]   = thread_id[TID_W-2:0];
        end
    end
endmodule

// File: rtl/tctx_ring_match.sv
module tctx_ring_match
    import tctx_cam_pkg::*;
#(
    parameter int CAM_W = 32,
    parameter int LS_W  = 16
) (
    input  logic                  fmt,
    input  logic                  ignore,
    input  logic [CAM_W-1:0]      tgt_cam,
    input  logic [LS_W-1:0]       lserv,
    input  logic [CAM_W-1:0]      hw_cam,
    input  logic [NUM_RINGS-1:0]  ring_vld,
    input  logic [CAM_W-1:0]      pool_cam,
    input  logic [CAM_W-1:0]      os_cam,
    input  logic [LS_W-1:0]       user_ls,
    output logic                  hit,
    output ring_id_e              ring
);
    logic phys_eq, pool_eq, os_eq, user_eq;

    assign phys_eq = ring_vld[SEL_PHYS] && (tgt_cam == hw_cam);
    assign pool_eq = ring_vld[SEL_POOL] && (tgt_cam == pool_cam);
    assign os_eq   = ring_vld[SEL_OS]   && (tgt_cam == os_cam);
    assign user_eq = ring_vld[SEL_USER] && (user_ls == lserv);

    always_comb begin
        hit  = 1'b0;
        ring = RING_NONE;
        if (!fmt) begin
            if (!ignore) begin
                if (phys_eq) begin
                    hit  = 1'b1;
                    ring = RING_PHYS;
                end else if (pool_eq) begin
                    hit  = 1'b1;
                    ring = RING_POOL;
                end else if (os_eq) begin
                    hit  = 1'b1;
                    ring = RING_OS;
                end
            end
        end else if (os_eq && user_eq) begin
            hit  = 1'b1;
            ring = RING_USER;
        end
    end
endmodule

// File: rtl/tctx_cam_match.sv
module tctx_cam_match
    import tctx_cam_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int IDX_W = 24,
    parameter int TID_W = 8,
    parameter int LS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_tid8,
    input  logic [BLK_W-1:0]  chip_blk,
    input  logic [TID_W-1:0]  thread_id,
    input  logic              wr_en,
    input  logic [1:0]        wr_ring,
    input  logic              wr_valid,
    input  logic [BLK_W+IDX_W-1:0] wr_word,
    input  logic              q_valid,
    input  logic              q_fmt,
    input  logic [BLK_W-1:0]  q_blk,
    input  logic [IDX_W-1:0]  q_idx,
    input  logic              q_ignore,
    input  logic [LS_W-1:0]   q_lserv,
    output logic              res_valid,
    output logic              res_hit,
    output logic [2:0]        res_ring
);
    localparam int CAM_W = BLK_W + IDX_W;

    logic [NUM_RINGS-1:0] ring_vld;
    logic [CAM_W-1:0]     pool_cam, os_cam, hw_cam;
    logic [LS_W-1:0]      user_ls;
    logic                 hit_d;
    ring_id_e             ring_d;

    tctx_ring_bank #(.WORD_W(CAM_W), .LS_W(LS_W)) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ring(wr_ring),
        .wr_valid(wr_valid), .wr_word(wr_word), .ring_vld(ring_vld),
        .pool_cam(pool_cam), .os_cam(os_cam), .user_ls(user_ls)
    );

    tctx_hw_cam #(.BLK_W(BLK_W), .CAM_W(CAM_W), .TID_W(TID_W)) hwcam_i (
        .cfg_tid8(cfg_tid8), .chip_blk(chip_blk), .thread_id(thread_id),
        .hw_cam(hw_cam)
    );

    tctx_ring_match #(.CAM_W(CAM_W), .LS_W(LS_W)) match_i (
        .fmt(q_fmt), .ignore(q_ignore), .tgt_cam({q_blk, q_idx}),
        .lserv(q_lserv), .hw_cam(hw_cam), .ring_vld(ring_vld),
        .pool_cam(pool_cam), .os_cam(os_cam), .user_ls(user_ls),
        .hit(hit_d), .ring(ring_d)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_ring  <= RING_NONE;
        end else begin
            res_valid <= q_valid;
            if (q_valid) begin
                res_hit  <= hit_d;
                res_ring <= ring_d;
            end
        end
    end
endmodule

// File: rtl/tctx_cam_match_chk.sv
module tctx_cam_match_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       q_valid,
    input logic       q_fmt,
    input logic       q_ignore,
    input logic       res_valid,
    input logic       res_hit,
    input logic [2:0] res_ring
);
    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> res_valid);
    assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |=> !res_valid);
    assert_miss_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !res_hit |-> res_ring == 3'd7);
    assert_hit_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_ring != 3'd7);
    assert_ignore_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_fmt && q_ignore) |=> !res_hit);
    assert_user_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_fmt) |=> (!res_hit || res_ring == 3'd0));
    assert_no_user_fmt0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && !q_fmt) |=> res_ring != 3'd0);
endmodule

bind tctx_cam_match tctx_cam_match_chk chk_i (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_fmt(q_fmt),
    .q_ignore(q_ignore), .res_valid(res_valid), .res_hit(res_hit),
    .res_ring(res_ring)
);

// File: tb/tctx_cam_match_tb_top.sv
module tctx_cam_match_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tid8 = 1'b0;
    logic [7:0]  chip_blk = 8'h00;
    logic [7:0]  thread_id = 8'h00;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ring = 2'd0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_word = '0;
    logic        q_valid = 1'b0;
    logic        q_fmt = 1'b0;
    logic [7:0]  q_blk = '0;
    logic [23:0] q_idx = '0;
    logic        q_ignore = 1'b0;
    logic [15:0] q_lserv = '0;
    logic        res_valid, res_hit;
    logic [2:0]  res_ring;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit          m_vld [4];
    logic [31:0] m_word [4];

    always #2 clk = ~clk;

    tctx_cam_match dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_tid8(cfg_tid8), .chip_blk(chip_blk),
        .thread_id(thread_id), .wr_en(wr_en), .wr_ring(wr_ring),
        .wr_valid(wr_valid), .wr_word(wr_word), .q_valid(q_valid),
        .q_fmt(q_fmt), .q_blk(q_blk), .q_idx(q_idx), .q_ignore(q_ignore),
        .q_lserv(q_lserv), .res_valid(res_valid), .res_hit(res_hit),
        .res_ring(res_ring)
    );

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [31:0] exp_hwcam();
        logic [31:0] low;
        low = cfg_tid8 ? (32'h100 | 32'(thread_id)) : (32'h80 | 32'(thread_id & 8'h7f));
        return (32'(chip_blk) << 24) | low;
    endfunction

    // returns {hit, ring code}
    function automatic logic [3:0] exp_result(input bit fmt, input bit ign,
                                              input logic [31:0] tgt, input logic [15:0] ls);
        if (!fmt) begin
            if (ign) return 4'b0111;
            if (m_vld[3] && tgt == exp_hwcam()) return 4'b1011;
            if (m_vld[2] && tgt == m_word[2]) return 4'b1010;
            if (m_vld[1] && tgt == m_word[1]) return 4'b1001;
            return 4'b0111;
        end
        if (m_vld[1] && tgt == m_word[1] && m_vld[0] && m_word[0][15:0] == ls)
            return 4'b1000;
        return 4'b0111;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: %s actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // One cycle: optional write (logical word) and optional lookup, then check.
    task automatic step(input bit we, input logic [1:0] wsel, input bit wv,
                        input logic [31:0] wlog, input bit qv, input bit fmt,
                        input bit ign, input logic [31:0] tgt,
                        input logic [15:0] ls, input string tag);
        logic [3:0] e;
        wr_en = we; wr_ring = wsel; wr_valid = wv; wr_word = bswap(wlog);
        q_valid = qv; q_fmt = fmt; q_ignore = ign;
        q_blk = tgt[31:24]; q_idx = tgt[23:0]; q_lserv = ls;
        e = exp_result(fmt, ign, tgt, ls);
        if (we) begin
            m_vld[wsel] = wv;
            m_word[wsel] = wlog;
        end
        @(negedge clk);
        wr_en = 1'b0; q_valid = 1'b0;
        check("R2", "res_valid", 32'(res_valid), 32'(qv));
        if (qv) begin
            check(tag, "res_hit", 32'(res_hit), 32'(e[3]));
            check(tag, "res_ring", 32'(res_ring), 32'(e[2:0]));
        end
    endtask

    task automatic wr(input logic [1:0] sel, input bit v, input logic [31:0] w);
        step(1'b1, sel, v, w, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0, "R11");
    endtask

    task automatic q(input bit fmt, input bit ign, input logic [31:0] tgt,
                     input logic [15:0] ls, input string tag);
        step(1'b0, 2'd0, 1'b0, 32'h0, 1'b1, fmt, ign, tgt, ls, tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] pool_c [4];
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 4; i++) begin m_vld[i] = 1'b0; m_word[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: outputs held in reset
        check("R1", "res_valid in reset", 32'(res_valid), 32'h0);
        check("R1", "res_ring in reset", 32'(res_ring), 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "res_hit after reset", 32'(res_hit), 32'h0);
        check("R1", "res_ring after reset", 32'(res_ring), 32'h7);
        chip_blk = 8'h3C; thread_id = 8'hA5; cfg_tid8 = 1'b0;
        q(1'b0, 1'b0, exp_hwcam(), 16'h0, "R1");           // all rings invalid

        // R3/R4: 7-bit mode, physical ring; stored word ignored
        wr(2'd3, 1'b1, 32'h1234_5678);
        q(1'b0, 1'b0, 32'h3C00_00A5, 16'h0, "R3");
        q(1'b0, 1'b0, 32'h1234_5678, 16'h0, "R4");
        // R3: 8-bit mode gives a different CAM for the same thread
        cfg_tid8 = 1'b1;
        q(1'b0, 1'b0, 32'h3C00_00A5, 16'h0, "R3");
        q(1'b0, 1'b0, 32'h3C00_01A5, 16'h0, "R3");

        // R5: priority fall-through with identical CAMs
        wr(2'd2, 1'b1, 32'h3C00_01A5);
        wr(2'd1, 1'b1, 32'h3C00_01A5);
        q(1'b0, 1'b0, 32'h3C00_01A5, 16'h0, "R5");
        wr(2'd3, 1'b0, 32'h0);
        q(1'b0, 1'b0, 32'h3C00_01A5, 16'h0, "R5");
        wr(2'd2, 1'b0, 32'h0);
        q(1'b0, 1'b0, 32'h3C00_01A5, 16'h0, "R6");
        // R7: ignore flag
        q(1'b0, 1'b1, 32'h3C00_01A5, 16'h0, "R7");

        // R8: user ring
        wr(2'd0, 1'b1, 32'hFFFF_0042);
        q(1'b1, 1'b0, 32'h3C00_01A5, 16'h0042, "R8");
        q(1'b1, 1'b0, 32'h3C00_01A5, 16'h0043, "R8");
        q(1'b1, 1'b0, 32'h3C00_01A6, 16'h0042, "R8");
        wr(2'd1, 1'b0, 32'h3C00_01A5);
        q(1'b1, 1'b0, 32'h3C00_01A5, 16'h0042, "R8");

        // R9: byte order, lane 0 carries the top byte
        step(1'b1, 2'd2, 1'b1, 32'h0102_0304, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0, "R9");
        q(1'b0, 1'b0, 32'h0102_0304, 16'h0, "R9");
        q(1'b0, 1'b0, 32'h0403_0201, 16'h0, "R9");

        // R2: write and lookup in the same cycle sees old contents
        step(1'b1, 2'd1, 1'b1, 32'h7700_0011, 1'b1, 1'b0, 1'b0, 32'h7700_0011, 16'h0, "R2");
        q(1'b0, 1'b0, 32'h7700_0011, 16'h0, "R2");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            bit do_w, do_q;
            if ($urandom % 50 == 0) cfg_tid8 = $urandom % 2;
            if ($urandom % 80 == 0) thread_id = 8'($urandom);
            pool_c[0] = exp_hwcam();
            pool_c[1] = 32'h1100_0042;
            pool_c[2] = 32'h0A00_1234;
            pool_c[3] = (n % 7 == 0) ? $urandom : 32'h3C00_00A5;
            do_w = ($urandom % 3) == 0;
            do_q = ($urandom % 4) != 0;
            step(do_w, 2'($urandom), ($urandom % 4) != 0,
                 {16'($urandom % 4 == 0 ? $urandom : 32'h0), 16'($urandom % 3)} ^
                     (($urandom % 2) ? pool_c[$urandom % 4] : 32'h0),
                 do_q, ($urandom % 3) == 0, ($urandom % 8) == 0,
                 pool_c[$urandom % 4], 16'($urandom % 3), "R5");
        end
        step(1'b0, 2'd0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h0, 16'h0, "R2");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule